// File: doc/BRIEF.md
# Weighted Pseudo-Random Reset Generator

This block is a stimulus source for built-in self-test of a sequential circuit. A maximal-length linear feedback shift register steps once per clock while enabled. Its state drives the pattern bus that feeds the primary inputs of the circuit under test. From the same state the block derives a weighted, active-low global reset for that circuit. The reset is the NAND of M distinct register stages, so it goes low only when all M stages hold 1. Over a long run that happens on about one vector in 2^M. Between two resets the circuit therefore gets, on average, enough clocks for state to travel its longest flip-flop path, provided M is chosen larger than that sequential depth.

A seed can be loaded at any time. A seed of all ones asserts the reset on the very first vector, so the circuit under test starts from a known state. A seed of all zeros would lock the register, so it is replaced with all ones. With enable low the register holds its state and the reset is released. The pattern bus and the reset output are both registered and change on the same clock edge, so every reset value belongs to the pattern shown beside it.

Top module: `wtrst_gen`

## Requirements
- R1: While and immediately after the synchronous active-high `rst`, `pat` is all ones and `cut_rst_n` is 1.
- R2: With `en` high and `load` low, each clock edge moves `pat[N-1:1]` to the old `pat[N-2:0]` and puts a feedback bit into `pat[0]`. The sequence never reaches zero, and it first returns to a starting value after exactly 2^N-1 steps.
- R3: Over one full period, each pattern bit is 0 in exactly 2^(N-1)-1 of the 2^N-1 vectors, which is a probability of about one half.
- R4: `cut_rst_n` is 0 exactly when `pat[M-1:0]` is all ones, on the same vector, while `en` is high.
- R5: Over one full period, `cut_rst_n` is low on exactly 2^(N-M) vectors. Likewise, `pat[1:0]` equals 2'b11 on exactly 2^(N-2) vectors, so a two-stage NAND is low with a probability of about one quarter.
- R6: When `load` is high, `pat` equals `seed` one edge later. If `en` is also high and the seed is all ones, `cut_rst_n` is 0 on that first vector.
- R7: A `load` with `seed` equal to zero gives `pat` equal to all ones.
- R8: With `en` low and `load` low, `pat` keeps its value and `cut_rst_n` is 1 after the next edge, even when `pat[M-1:0]` is all ones.
- R9: `load` takes effect even when `en` is low, and `cut_rst_n` is then 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Step the register and allow the weighted reset |
| load | input | 1 | Load `seed` on this edge |
| seed | input | N | Starting state; zero is replaced with all ones |
| pat | output | N | Registered pattern bus to the circuit under test |
| cut_rst_n | output | 1 | Registered weighted reset, active low |

## Verification
The checker assumes that `rst` is high at the first clock edge, so the register never holds an unknown or zero value. It also assumes that `en`, `load` and `seed` are settled before each rising edge. The bench starts every scenario under reset and changes inputs only on falling edges. Zero seeds reach the block only through the load path, which replaces them.

// File: rtl/wtrst_pkg.sv
package wtrst_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } lfsr_op_e;

    localparam int unsigned MIN_WIDTH = 3;
    localparam int unsigned MAX_WIDTH = 16;

    // Feedback mask for a left-shifting register: bit k set means stage k
    // feeds the XOR that enters stage 0. Each entry is a primitive polynomial.
    function automatic logic [31:0] tap_mask(input int unsigned width);
        logic [31:0] m;
        case (width)
            3:       m = 32'h0000_0006;
            4:       m = 32'h0000_000C;
            5:       m = 32'h0000_0014;
            6:       m = 32'h0000_0030;
            7:       m = 32'h0000_0060;
            8:       m = 32'h0000_00B8;
            9:       m = 32'h0000_0110;
            10:      m = 32'h0000_0240;
            11:      m = 32'h0000_0500;
            12:      m = 32'h0000_0829;
            13:      m = 32'h0000_100D;
            14:      m = 32'h0000_2015;
            15:      m = 32'h0000_6000;
            16:      m = 32'h0000_D008;
            default: m = 32'h0000_0000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wtrst_lfsr.sv
module wtrst_lfsr
    import wtrst_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  lfsr_op_e     op,
    input  logic [N-1:0] seed,
    output logic [N-1:0] state_q,
    output logic [N-1:0] state_d
);
    localparam logic [31:0]  MASK_W = tap_mask(N);
    localparam logic [N-1:0] MASK   = MASK_W[N-1:0];
    localparam logic [N-1:0] ONES   = {N{1'b1}};

    logic         fb;
    logic [N-1:0] seed_safe;

    always_comb begin
        fb        = ^(state_q & MASK);
        seed_safe = (seed == '0) ? ONES : seed;
        unique case (op)
            OP_LOAD: state_d = seed_safe;
            OP_STEP: state_d = {state_q[N-2:0], fb};
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ONES;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/wtrst_weight.sv
module wtrst_weight #(
    parameter int unsigned N = 8,
    parameter int unsigned M = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [N-1:0] state_d,
    output logic         rst_n_q
);
    logic [M-1:0] picked;
    logic         all_set;

    for (genvar i = 0; i < M; i++) begin : g_pick
        assign picked[i] = state_d[i];
    end

    assign all_set = &picked;

    always_ff @(posedge clk) begin
        if (rst)      rst_n_q <= 1'b1;
        else if (!en) rst_n_q <= 1'b1;
        else          rst_n_q <= ~all_set;
    end

endmodule

// File: rtl/wtrst_gen.sv
module wtrst_gen
    import wtrst_pkg::*;
#(
    parameter int unsigned N = 8,
    parameter int unsigned M = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         load,
    input  logic [N-1:0] seed,
    output logic [N-1:0] pat,
    output logic         cut_rst_n
);
    if (N < MIN_WIDTH || N > MAX_WIDTH || M < 1 || N < M + 1) begin : g_bad_params
        $error("wtrst_gen: unsupported N/M combination");
    end

    lfsr_op_e     op;
    logic [N-1:0] state_d;

    always_comb begin
        if (load)    op = OP_LOAD;
        else if (en) op = OP_STEP;
        else         op = OP_HOLD;
    end

    wtrst_lfsr #(.N(N)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .seed    (seed),
        .state_q (pat),
        .state_d (state_d)
    );

    wtrst_weight #(.N(N), .M(M)) u_weight (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .state_d (state_d),
        .rst_n_q (cut_rst_n)
    );

endmodule

// File: rtl/wtrst_gen_chk.sv
module wtrst_gen_chk #(
    parameter int unsigned N = 8,
    parameter int unsigned M = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         load,
    input logic [N-1:0] seed,
    input logic [N-1:0] pat,
    input logic         cut_rst_n
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pat == {N{1'b1}} && cut_rst_n));

    // R2
    a_r2_never_zero: assert property (@(posedge clk) disable iff (rst)
        pat != '0);

    a_r2_shift: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> pat[N-1:1] == $past(pat[N-2:0]));

    // R4
    a_r4_low_needs_ones: assert property (@(posedge clk) disable iff (rst)
        !cut_rst_n |-> &pat[M-1:0]);

    // R6
    a_r6_ones_seed: assert property (@(posedge clk) disable iff (rst)
        (load && en && seed == {N{1'b1}}) |=> (!cut_rst_n && pat == {N{1'b1}}));

    // R7
    a_r7_zero_seed: assert property (@(posedge clk) disable iff (rst)
        (load && seed == '0) |=> pat == {N{1'b1}});

    // R8
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> ($stable(pat) && cut_rst_n));

    // R9
    a_r9_load_idle: assert property (@(posedge clk) disable iff (rst)
        (load && !en && seed != '0) |=> (pat == $past(seed) && cut_rst_n));

endmodule

bind wtrst_gen wtrst_gen_chk #(.N(N), .M(M)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .load      (load),
    .seed      (seed),
    .pat       (pat),
    .cut_rst_n (cut_rst_n)
);

// File: tb/sim_wtrst_gen.sv
module sim_wtrst_gen;
    localparam int unsigned N = 8;
    localparam int unsigned M = 3;
    localparam int unsigned PERIOD = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         load = 1'b0;
    logic [N-1:0] seed = '0;
    logic [N-1:0] pat;
    logic         cut_rst_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wtrst_gen #(.N(N), .M(M)) u0 (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
        .pat(pat), .cut_rst_n(cut_rst_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0; load = 1'b0; seed = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(pat == 8'hFF, "R1 pat after reset", pat, 8'hFF);
        chk(cut_rst_n == 1'b1, "R1 cut_rst_n after reset", cut_rst_n, 1);
    endtask

    task automatic t_ones_seed();
        do_reset();
        load = 1'b1; en = 1'b1; seed = 8'hFF;
        @(negedge clk);
        load = 1'b0; en = 1'b0;
        chk(pat == 8'hFF, "R6 pat after ones seed", pat, 8'hFF);
        chk(cut_rst_n == 1'b0, "R6 reset on first vector", cut_rst_n, 0);
    endtask

    task automatic t_zero_seed();
        do_reset();
        load = 1'b1; en = 1'b1; seed = 8'h00;
        @(negedge clk);
        load = 1'b0; en = 1'b0;
        chk(pat == 8'hFF, "R7 zero seed replaced", pat, 8'hFF);
    endtask

    task automatic t_period(input logic [N-1:0] s);
        logic [N-1:0] prev;
        int rst_lo = 0, b0_zero = 0, b7_zero = 0, pair = 0;
        int bad_r4 = 0, bad_shift = 0, zero_seen = 0, early = 0;
        do_reset();
        load = 1'b1; en = 1'b1; seed = s;
        @(negedge clk);
        load = 1'b0;
        chk(pat == s, "R6 pat equals seed", pat, s);
        for (int v = 0; v < PERIOD; v++) begin
            if (cut_rst_n != ~&pat[M-1:0]) bad_r4++;
            if (!cut_rst_n) rst_lo++;
            if (!pat[0]) b0_zero++;
            if (!pat[N-1]) b7_zero++;
            if (pat[1:0] == 2'b11) pair++;
            prev = pat;
            @(negedge clk);
            if (pat[N-1:1] != prev[N-2:0]) bad_shift++;
            if (pat == '0) zero_seen++;
            if (v < PERIOD - 1 && pat == s) early++;
        end
        en = 1'b0;
        chk(bad_r4 == 0, "R4 reset matches selected stages", bad_r4, 0);
        chk(bad_shift == 0, "R2 shift relation", bad_shift, 0);
        chk(zero_seen == 0, "R2 zero state reached", zero_seen, 0);
        chk(early == 0, "R2 early repeat", early, 0);
        chk(pat == s, "R2 return after full period", pat, s);
        chk(rst_lo == (1 << (N - M)), "R5 reset count per period", rst_lo, 1 << (N - M));
        chk(pair == (1 << (N - 2)), "R5 two-stage ones count", pair, 1 << (N - 2));
        chk(b0_zero == (1 << (N - 1)) - 1, "R3 bit0 zero count", b0_zero, (1 << (N - 1)) - 1);
        chk(b7_zero == (1 << (N - 1)) - 1, "R3 top bit zero count", b7_zero, (1 << (N - 1)) - 1);
    endtask

    task automatic t_hold();
        do_reset();
        load = 1'b1; en = 1'b1; seed = 8'hFF;
        @(negedge clk);
        load = 1'b0; en = 1'b0;
        @(negedge clk);
        chk(pat == 8'hFF, "R8 pat held", pat, 8'hFF);
        chk(cut_rst_n == 1'b1, "R8 reset released while disabled", cut_rst_n, 1);
        repeat (3) @(negedge clk);
        chk(pat == 8'hFF, "R8 pat still held", pat, 8'hFF);
    endtask

    task automatic t_load_idle();
        do_reset();
        load = 1'b1; en = 1'b0; seed = 8'hA7;
        @(negedge clk);
        load = 1'b0;
        chk(pat == 8'hA7, "R9 load with enable low", pat, 8'hA7);
        chk(cut_rst_n == 1'b1, "R9 reset high on idle load", cut_rst_n, 1);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ones_seed();
        t_zero_seed();
        t_period(8'h01);
        t_period(8'h5C);
        t_hold();
        t_load_idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule